// File: doc/BRIEF.md
# Writable 12-bit Color Palette with Source Select

This block models a palette card that sits between a video pixel stream and the color output. It holds a small table of colors. Each entry has 4 bits each of red, green and blue. A host changes entries with 16-bit I/O writes. The upper address byte names the entry and picks which components are written, and the data byte carries the intensity nibbles. One write with the component-select bit low loads red and blue together. A second write with the bit high loads green.

On the video side, a 4-bit pixel index looks up its 12-bit color, which appears on the output one clock later. An external select bit, taken from a general-purpose output port elsewhere in the system, chooses the color source. It can pick the palette color or pass the main unit's own 12-bit color straight through, delayed by the same one clock so that the two paths stay aligned. After reset the table holds the main unit's fixed 16-color mapping, so flipping the select bit right after reset changes nothing on screen.

Top module: `pal12_board`

## Requirements
- R1: Synchronous active-high reset drives `rgb_out` to 0. It loads every entry k with the fixed mapping, where bit 3 of k is intensity and bits 2/1/0 are green/red/blue. A component whose bit is set reads 15 with intensity and 10 without. A component whose bit is clear reads 5 with intensity and 0 without.
- R2: A write with `io_addr_hi[0]`=0 loads the addressed entry's blue from `io_data[3:0]` and its red from `io_data[7:4]`. Green is left unchanged.
- R3: A write with `io_addr_hi[0]`=1 loads the addressed entry's green from `io_data[3:0]`. Red, blue and `io_data[7:4]` have no effect.
- R4: A write happens only when `io_port` equals 8'hAE. Any other port value changes no entry.
- R5: The entry number is `io_addr_hi[4:1]`. Bits 7..5 of `io_addr_hi` are ignored, so addresses that differ only in those bits reach the same entry.
- R6: `rgb_out` packs red in bits 11..8, green in bits 7..4 and blue in bits 3..0. It shows the color of `pix_idx` one clock after `pix_idx` is sampled.
- R7: A lookup in the same clock as a write to that entry returns the old color. The next lookup returns the new color.
- R8: With `use_native`=1, `rgb_out` shows `native_rgb` sampled one clock earlier. With `use_native`=0 it shows the palette color.
- R9: With `io_wr`=0, no entry changes, whatever the other I/O inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_port | input | 8 | Low I/O address byte (port number) |
| io_addr_hi | input | 8 | High I/O address byte: entry number in bits 4..1, component select in bit 0 |
| io_data | input | 8 | Write data: two intensity nibbles |
| pix_idx | input | 4 | Pixel color index to look up |
| native_rgb | input | 12 | Main unit's own color for the current pixel |
| use_native | input | 1 | Source select: 0 palette, 1 main unit color |
| rgb_out | output | 12 | Selected color, one clock after its inputs |

## Verification
The bench targets a write and a lookup of the same entry in one clock. A design that forwards the new data would show the new color a cycle early instead of the old one. It writes green with a nonzero upper data nibble and follows with red/blue writes. This catches a design that lets either write clobber the other components. It aims writes at a neighbouring port number, with the strobe low, and with the high address bits set. These catch designs that decode the port loosely or fold the upper bits into the entry number. It also toggles the source select every cycle against random native colors. A design that forgets to delay the native path would put the current cycle's color on the output instead of the last one.

// File: rtl/pal12_pkg.sv
package pal12_pkg;

    localparam int COMP_W   = 4;
    localparam int RGB_W    = 3 * COMP_W;
    localparam int ENTRY_W  = 4;
    localparam int N_ENTRY  = 1 << ENTRY_W;
    localparam int PORT_W   = 8;
    localparam int HI_W     = 8;
    localparam int DATA_W   = 8;
    localparam logic [PORT_W-1:0] PAL_PORT = 8'hAE;

    localparam logic [COMP_W-1:0] LVL_MAX  = {COMP_W{1'b1}};
    localparam logic [COMP_W-1:0] LVL_MID  = COMP_W'((32'(LVL_MAX) * 2) / 3);
    localparam logic [COMP_W-1:0] LVL_LOW  = COMP_W'(32'(LVL_MAX) / 3);
    localparam logic [COMP_W-1:0] LVL_NONE = '0;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    typedef enum logic {
        SEL_RB = 1'b0,
        SEL_G  = 1'b1
    } comp_sel_e;

    typedef struct packed {
        logic              en;
        comp_sel_e         sel;
        logic [ENTRY_W-1:0] idx;
        logic [COMP_W-1:0] lo;
        logic [COMP_W-1:0] hi;
    } wr_cmd_t;

    function automatic logic [COMP_W-1:0] level_of(input logic on, input logic bright);
        if (on) return bright ? LVL_MAX : LVL_MID;
        return bright ? LVL_LOW : LVL_NONE;
    endfunction

    // Fixed 16-color mapping: code bit3 intensity, bit2 green, bit1 red, bit0 blue
    function automatic rgb_t native_color(input logic [3:0] code);
        rgb_t c;
        c.r = level_of(code[1], code[3]);
        c.g = level_of(code[2], code[3]);
        c.b = level_of(code[0], code[3]);
        return c;
    endfunction

endpackage

// File: rtl/pal12_decode.sv
module pal12_decode
    import pal12_pkg::*;
#(
    parameter logic [PORT_W-1:0] PORT_ADDR = PAL_PORT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [HI_W-1:0]   io_addr_hi,
    input  logic [DATA_W-1:0] io_data,
    output wr_cmd_t           cmd
);

    always_comb begin
        cmd.en  = io_wr && (io_port == PORT_ADDR);
        cmd.sel = comp_sel_e'(io_addr_hi[0]);
        cmd.idx = io_addr_hi[ENTRY_W:1];
        cmd.lo  = io_data[COMP_W-1:0];
        cmd.hi  = io_data[DATA_W-1:COMP_W];
    end

    // R4 / R9: an enable never appears without a strobe at the palette port
    a_r4_port_match: assert property (@(posedge clk) disable iff (rst)
        cmd.en |-> (io_wr && io_port == PORT_ADDR));
    a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !io_wr |-> !cmd.en);

endmodule

// File: rtl/pal12_table.sv
module pal12_table
    import pal12_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_cmd_t            cmd,
    input  logic [ENTRY_W-1:0] rd_idx,
    output rgb_t               rd_data
);

    rgb_t tbl [N_ENTRY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_ENTRY; k++) begin
                tbl[k] <= native_color(4'(k));
            end
            rd_data <= '0;
        end else begin
            rd_data <= tbl[rd_idx];
            if (cmd.en) begin
                if (cmd.sel == SEL_RB) begin
                    tbl[cmd.idx].r <= cmd.hi;
                    tbl[cmd.idx].b <= cmd.lo;
                end else begin
                    tbl[cmd.idx].g <= cmd.lo;
                end
            end
        end
    end

    // R1: every entry holds its fixed mapping right after reset
    for (genvar k = 0; k < N_ENTRY; k++) begin : g_chk
        a_r1_reset_entry: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> tbl[k] == native_color(4'(k)));
    end

    // R2: red/blue write leaves green alone
    a_r2_rb_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd.en) && $past(cmd.sel) == SEL_RB) |->
        (tbl[$past(cmd.idx)].r == $past(cmd.hi) &&
         tbl[$past(cmd.idx)].b == $past(cmd.lo) &&
         tbl[$past(cmd.idx)].g == $past(tbl[cmd.idx].g)));

    // R3: green write leaves red and blue alone
    a_r3_g_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd.en) && $past(cmd.sel) == SEL_G) |->
        (tbl[$past(cmd.idx)].g == $past(cmd.lo) &&
         tbl[$past(cmd.idx)].r == $past(tbl[cmd.idx].r) &&
         tbl[$past(cmd.idx)].b == $past(tbl[cmd.idx].b)));

endmodule

// File: rtl/pal12_outmux.sv
module pal12_outmux
    import pal12_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rgb_t pal_in,
    input  rgb_t native_in,
    input  logic bypass,
    output rgb_t rgb_out
);

    rgb_t native_q;
    logic bypass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            native_q <= '0;
            bypass_q <= 1'b0;
        end else begin
            native_q <= native_in;
            bypass_q <= bypass;
        end
    end

    always_comb begin
        rgb_out = bypass_q ? native_q : pal_in;
    end

    // R8: selected native color is the one presented a clock earlier
    a_r8_native_path: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bypass)) |-> rgb_out == $past(native_in));
    a_r8_palette_path: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bypass)) |-> rgb_out == pal_in);

endmodule

// File: rtl/pal12_board.sv
module pal12_board
    import pal12_pkg::*;
#(
    parameter logic [PORT_W-1:0] PORT_ADDR = PAL_PORT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_wr,
    input  logic [PORT_W-1:0]  io_port,
    input  logic [HI_W-1:0]    io_addr_hi,
    input  logic [DATA_W-1:0]  io_data,
    input  logic [ENTRY_W-1:0] pix_idx,
    input  logic [RGB_W-1:0]   native_rgb,
    input  logic               use_native,
    output logic [RGB_W-1:0]   rgb_out
);

    wr_cmd_t cmd;
    rgb_t    pal_q;
    rgb_t    mux_out;

    pal12_decode #(.PORT_ADDR(PORT_ADDR)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .io_wr      (io_wr),
        .io_port    (io_port),
        .io_addr_hi (io_addr_hi),
        .io_data    (io_data),
        .cmd        (cmd)
    );

    pal12_table u_table (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .rd_idx  (pix_idx),
        .rd_data (pal_q)
    );

    pal12_outmux u_outmux (
        .clk       (clk),
        .rst       (rst),
        .pal_in    (pal_q),
        .native_in (rgb_t'(native_rgb)),
        .bypass    (use_native),
        .rgb_out   (mux_out)
    );

    assign rgb_out = mux_out;

endmodule

// File: tb/pal12_board_test.sv
module pal12_board_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic [7:0]  io_addr_hi = 8'h00;
    logic [7:0]  io_data = 8'h00;
    logic [3:0]  pix_idx = 4'h0;
    logic [11:0] native_rgb = 12'h000;
    logic        use_native = 1'b0;
    wire  [11:0] rgb_out;

    int checks = 0;
    int errors = 0;
    logic [11:0] model [16];

    always #10 clk = ~clk;

    pal12_board uut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port),
        .io_addr_hi(io_addr_hi), .io_data(io_data), .pix_idx(pix_idx),
        .native_rgb(native_rgb), .use_native(use_native), .rgb_out(rgb_out)
    );

    function automatic logic [3:0] lvl(input logic on, input logic br);
        return on ? (br ? 4'd15 : 4'd10) : (br ? 4'd5 : 4'd0);
    endfunction

    function automatic logic [11:0] dflt(input int k);
        logic [3:0] c = 4'(k);
        return {lvl(c[1], c[3]), lvl(c[2], c[3]), lvl(c[0], c[3])};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, predict, step, compare at next negedge
    task automatic cycle(input string tag, input logic wr, input logic [7:0] port,
                         input logic [7:0] hi, input logic [7:0] d, input logic [3:0] idx,
                         input logic sel, input logic [11:0] nat);
        logic [11:0] exp;
        io_wr = wr; io_port = port; io_addr_hi = hi; io_data = d;
        pix_idx = idx; use_native = sel; native_rgb = nat;
        exp = sel ? nat : model[idx];
        if (wr && port == 8'hAE) begin
            if (!hi[0]) begin
                model[hi[4:1]][11:8] = d[7:4];
                model[hi[4:1]][3:0]  = d[3:0];
            end else begin
                model[hi[4:1]][7:4] = d[3:0];
            end
        end
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
        check(tag, rgb_out, exp);
    endtask

    task automatic look(input string tag, input logic [3:0] idx);
        cycle(tag, 1'b0, 8'h00, 8'h00, 8'h00, idx, 1'b0, 12'h000);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 16; k++) model[k] = dflt(k);
        use_native = 1'b1; native_rgb = 12'hFFF; io_wr = 1'b1; io_port = 8'hAE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset output", rgb_out, 12'h000);
        io_wr = 1'b0;
        rst = 1'b0;

        // R1 defaults and R6 latency through every index
        for (int k = 0; k < 16; k++) look("R1 R6 default entry", 4'(k));

        // R2 red/blue write to entry 5
        cycle("R2 write", 1'b1, 8'hAE, 8'h0A, 8'h3C, 4'h0, 1'b0, 12'h000);
        look("R2 red/blue loaded, green kept", 4'h5);
        // R3 green write with nonzero upper nibble
        cycle("R3 write", 1'b1, 8'hAE, 8'h0B, 8'hF7, 4'h0, 1'b0, 12'h000);
        look("R3 green loaded, red/blue kept", 4'h5);
        // R4 wrong port
        cycle("R4 write", 1'b1, 8'hAF, 8'h0C, 8'h99, 4'h0, 1'b0, 12'h000);
        look("R4 other port ignored", 4'h6);
        cycle("R4 write", 1'b1, 8'h2E, 8'h0D, 8'h99, 4'h0, 1'b0, 12'h000);
        look("R4 other port ignored green", 4'h6);
        // R9 strobe low
        cycle("R9 no strobe", 1'b0, 8'hAE, 8'h0E, 8'h55, 4'h0, 1'b0, 12'h000);
        look("R9 entry 7 unchanged", 4'h7);
        // R5 alias of upper bits onto entry 9
        cycle("R5 write", 1'b1, 8'hAE, 8'hF2, 8'h1E, 4'h0, 1'b0, 12'h000);
        look("R5 aliased entry 9", 4'h9);
        look("R5 entry 1 untouched", 4'h1);
        // R7 same-cycle write and lookup
        cycle("R7 old value on collision", 1'b1, 8'hAE, 8'h04, 8'hA5, 4'h2, 1'b0, 12'h000);
        look("R7 new value next", 4'h2);
        cycle("R7 old green on collision", 1'b1, 8'hAE, 8'h05, 8'h0C, 4'h2, 1'b0, 12'h000);
        look("R7 new green next", 4'h2);
        // R8 select toggling
        cycle("R8 native", 1'b0, 8'h00, 8'h00, 8'h00, 4'h3, 1'b1, 12'h5A3);
        cycle("R8 back to palette", 1'b0, 8'h00, 8'h00, 8'h00, 4'h3, 1'b0, 12'h777);
        cycle("R8 native again", 1'b0, 8'h00, 8'h00, 8'h00, 4'hF, 1'b1, 12'h0F0);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic        wr  = ($urandom % 3) != 0;
            logic [7:0]  pt  = (($urandom % 5) == 0) ? 8'($urandom) : 8'hAE;
            logic [7:0]  hi  = 8'($urandom);
            logic [7:0]  d   = 8'($urandom);
            logic [3:0]  ix  = (($urandom % 4) == 0) ? hi[4:1] : 4'($urandom);
            logic        sl  = ($urandom % 4) == 0;
            logic [11:0] nt  = 12'($urandom);
            string tag;
            if (sl) tag = "R8 random native";
            else if (wr && pt == 8'hAE && ix == hi[4:1]) tag = "R7 random collision";
            else if (!hi[0]) tag = "R2 R4 R5 R6 random lookup";
            else tag = "R3 R9 random lookup";
            cycle(tag, wr, pt, hi, d, ix, sl, nt);
        end
        for (int k = 0; k < 16; k++) look("R6 final sweep", 4'(k));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule